// File: doc/BRIEF.md
# HDB3 Line Codec

This block converts between a unipolar bit stream and a three-level line code. The level is carried on two rail signals, one for positive pulses and one for negative pulses. In the transmit direction, each accepted data bit leaves as a symbol on the rails. A one becomes a pulse whose polarity alternates from one mark to the next. A zero becomes an empty symbol. Any run of four zeros is rewritten so that the line never stays empty for long, which keeps timing content on the line. The rewritten run ends in a pulse that deliberately breaks the alternation. The rewrite is chosen so that these deliberate breaks themselves alternate in polarity, which keeps the line free of DC.

In the receive direction, the rails are turned back into bits. The block spots each deliberate break, together with the balancing pulse that may come before it, and removes them. It raises a code-error flag on symbols that cannot occur on a well-formed line.

Both directions accept one symbol or bit per clock in which their valid input is high. Each has a fixed delay of four accepted items. A host feeds bits in on one side and reads rail symbols out on the other. A far end that receives those rails feeds them to the decoder.

Top module: `hdb3_codec`

## Requirements
- R1: On the encoder output, a data one that is not part of a substitution is sent as a pulse opposite in polarity to the previous pulse. Positive is encoded as pos=1, neg=0, negative as pos=0, neg=1, and empty as both low. The two rails are never high together.
- R2: The encoder output never carries more than three empty symbols in a row.
- R3: In a run of four input zeros, the fourth zero is sent as a violation pulse with the same polarity as the pulse just before it.
- R4: For the first zero of such a run, the encoder looks at the number of pulses sent since the previous violation. If that number is even, the first zero is sent as a balancing pulse opposite to the previous pulse, giving B00V. If it is odd, the first zero stays empty, giving 000V.
- R5: Consecutive violation pulses on the encoder output have opposite polarity.
- R6: Reset is synchronous and active low, and clears all outputs. After reset the previous polarity is taken as negative and the pulse count as even. So a first run of four zeros is sent as positive, empty, empty, positive.
- R7: Encoder delay is four accepted bits. tx_sym_valid is high in the cycle after an accepted bit, once four earlier bits have been accepted since reset, and low otherwise.
- R8: The decoder outputs each received symbol as a bit four accepted symbols later. A pulse is decoded as one unless it has the same polarity as the previous pulse; such a violation is decoded as zero. When exactly two empty symbols separate a violation from the previous pulse, that earlier pulse is also decoded as zero. After reset the previous polarity is taken as negative.
- R9: The decoder raises rx_code_err, and outputs zero, in three cases: a violation preceded by fewer than two or by more than three empty symbols; the fourth and every later consecutive empty symbol; and a symbol with both rails high. A symbol with both rails high counts as empty and leaves the stored polarity unchanged.
- R10: Encoder rails fed straight into the decoder give back the original bit sequence with no code error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Transmit bit is accepted this cycle |
| tx_bit | input | 1 | Transmit data bit |
| tx_sym_valid | output | 1 | A rail symbol is presented this cycle |
| tx_pos | output | 1 | Positive pulse on the transmit line |
| tx_neg | output | 1 | Negative pulse on the transmit line |
| rx_valid | input | 1 | Receive symbol is accepted this cycle |
| rx_pos | input | 1 | Positive pulse on the receive line |
| rx_neg | input | 1 | Negative pulse on the receive line |
| rx_bit_valid | output | 1 | A decoded bit is presented this cycle |
| rx_bit | output | 1 | Decoded data bit |
| rx_code_err | output | 1 | The decoded symbol broke the line code |

## Verification
The assertions take two things for granted: the valid inputs are low while reset is applied, and the encoder input stream is never reordered. Taken together, the zero-run and violation-alternation checks then hold over the whole encoder output, including across gaps in tx_valid. The stimulus respects these assumptions. It holds both valid inputs low during reset, inserts random idle cycles only between accepted items, and changes inputs only on the falling clock edge. On the decoder side, legal rail pairs are mixed with deliberately malformed symbols (same-polarity pairs, long empty runs, both rails high). This exercises the error path while every expectation still comes from a bench model of the receive rules.

// File: rtl/hdb3_pkg.sv
// Shared definitions for the HDB3 codec.
// Assumes: the substitution length is fixed by the line code at four.
package hdb3_pkg;

    localparam int RUN_LEN = 4;

    // One slot of the encoder look-ahead line.
    typedef struct packed {
        logic full;   // slot holds an accepted bit
        logic data;   // the accepted bit
        logic viol;   // slot is the last zero of a substituted run
        logic bal;    // slot is the first zero of a substituted run
    } enc_slot_t;

    // One slot of the decoder delay line.
    typedef struct packed {
        logic full;   // slot holds an accepted symbol
        logic mark;   // decoded bit value
        logic err;    // symbol broke the line code
    } dec_slot_t;

endpackage

// File: rtl/hdb3_enc.sv
// HDB3 encoder: takes unipolar bits and emits rail symbols through a
// look-ahead line of RUN slots. A zero run is detected as its last zero
// enters; whether its first zero becomes a balancing pulse is settled
// when that slot leaves, using the pulse parity counted up to that point.
// Assumes: in_valid is low during reset.
module hdb3_enc
    import hdb3_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_pos,
    output logic out_neg
);

    localparam int CW   = $clog2(RUN + 1);
    localparam int LAST = RUN - 1;
    localparam logic [CW-1:0] SUB_AT = CW'(RUN - 1);

    enc_slot_t [RUN-1:0] slot_q;
    enc_slot_t [RUN-1:0] slot_nxt;
    enc_slot_t           head;
    logic [CW-1:0]       zrun_q;
    logic                last_pos_q;   // polarity of the most recent pulse
    logic                odd_q;        // odd number of pulses since last violation
    logic                subst;
    logic                pulse;
    logic                pulse_pos;
    logic                last_pos_d;
    logic                odd_d;
    logic                emit;

    // Flag the incoming zero that completes a run of RUN zeros.
    always_comb subst = in_valid & ~in_bit & (zrun_q == SUB_AT);

    // Build the shifted line; the slot reaching the exit may be marked balancing.
    always_comb begin
        slot_nxt[0] = '{full: 1'b1, data: in_bit, viol: subst, bal: 1'b0};
        for (int i = 1; i < RUN; i++) begin
            slot_nxt[i] = slot_q[i-1];
        end
        slot_nxt[LAST].bal = subst;
    end

    // Choose the symbol for the slot leaving the line.
    always_comb begin
        head       = slot_q[LAST];
        emit       = in_valid & head.full;
        pulse      = 1'b0;
        pulse_pos  = last_pos_q;
        last_pos_d = last_pos_q;
        odd_d      = odd_q;
        if (head.viol) begin
            pulse     = 1'b1;
            pulse_pos = last_pos_q;
            odd_d     = 1'b0;
        end else if (head.bal && !odd_q) begin
            pulse      = 1'b1;
            pulse_pos  = ~last_pos_q;
            last_pos_d = ~last_pos_q;
            odd_d      = 1'b1;
        end else if (head.data) begin
            pulse      = 1'b1;
            pulse_pos  = ~last_pos_q;
            last_pos_d = ~last_pos_q;
            odd_d      = ~odd_q;
        end
    end

    // Advance the look-ahead line on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (in_valid) begin
            slot_q <= slot_nxt;
        end
    end

    // Count input zeros since the last one or substitution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun_q <= '0;
        end else if (in_valid) begin
            if (in_bit || subst) zrun_q <= '0;
            else                 zrun_q <= zrun_q + 1'b1;
        end
    end

    // Register rail outputs and the polarity/parity state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_pos    <= 1'b0;
            out_neg    <= 1'b0;
            last_pos_q <= 1'b0;
            odd_q      <= 1'b0;
        end else begin
            out_valid <= emit;
            out_pos   <= emit & pulse & pulse_pos;
            out_neg   <= emit & pulse & ~pulse_pos;
            if (emit) begin
                last_pos_q <= last_pos_d;
                odd_q      <= odd_d;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [2:0] idle_q;     // consecutive empty symbols sent
    logic       v_pos_q;    // polarity of the previous violation
    logic       v_seen_q;

    // Track empty symbols on the line for the zero-run check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (out_valid) begin
            if (out_pos || out_neg) idle_q <= '0;
            else if (idle_q != 3'd7) idle_q <= idle_q + 1'b1;
        end
    end

    // Remember the previous violation polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_pos_q  <= 1'b0;
            v_seen_q <= 1'b0;
        end else if (emit && head.viol) begin
            v_pos_q  <= last_pos_q;
            v_seen_q <= 1'b1;
        end
    end

    a_r1_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_pos && out_neg));

    a_r2_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q < 3'(RUN));

    a_r5_viol_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && head.viol && v_seen_q) |-> (last_pos_q != v_pos_q));

    a_r7_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

endmodule

// File: rtl/hdb3_dec.sv
// HDB3 decoder: turns rail symbols back into bits through a delay line of
// RUN slots. A pulse matching the previous polarity is a violation; it
// is cleared, and a balancing pulse three slots earlier is cleared as it
// moves to the line exit. Malformed symbols are flagged.
// Assumes: in_valid is low during reset.
module hdb3_dec
    import hdb3_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_pos,
    input  logic in_neg,
    output logic out_valid,
    output logic out_bit,
    output logic out_err
);

    localparam int CW   = $clog2(RUN + 1);
    localparam int LAST = RUN - 1;
    localparam logic [CW-1:0] GAP_BAL = CW'(RUN - 2);
    localparam logic [CW-1:0] GAP_PLN = CW'(RUN - 1);
    localparam logic [CW-1:0] Z_SAT   = CW'(RUN);

    dec_slot_t [RUN-1:0] slot_q;
    dec_slot_t [RUN-1:0] slot_nxt;
    dec_slot_t           head;
    logic [CW-1:0]       zcnt_q;       // empty symbols since the last pulse
    logic                last_pos_q;
    logic                is_pulse;
    logic                clash;
    logic                viol;
    logic                viol_ok;
    logic                clear_b;
    logic                err_new;
    logic                take;

    // Classify the incoming symbol.
    always_comb begin
        is_pulse = in_pos ^ in_neg;
        clash    = in_pos & in_neg;
        viol     = is_pulse & (in_pos == last_pos_q);
        viol_ok  = (zcnt_q == GAP_BAL) | (zcnt_q == GAP_PLN);
        clear_b  = viol & (zcnt_q == GAP_BAL);
        err_new  = (viol & ~viol_ok) | clash | (~is_pulse & (zcnt_q >= GAP_PLN));
    end

    // Build the shifted line, removing a balancing pulse when found.
    always_comb begin
        slot_nxt[0] = '{full: 1'b1, mark: is_pulse & ~viol, err: err_new};
        for (int i = 1; i < RUN; i++) begin
            slot_nxt[i] = slot_q[i-1];
        end
        if (clear_b) slot_nxt[LAST].mark = 1'b0;
        head = slot_q[LAST];
        take = in_valid & head.full;
    end

    // Advance the delay line on each accepted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (in_valid) begin
            slot_q <= slot_nxt;
        end
    end

    // Track previous pulse polarity and the empty-symbol run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zcnt_q     <= '0;
            last_pos_q <= 1'b0;
        end else if (in_valid) begin
            if (is_pulse) begin
                zcnt_q     <= '0;
                last_pos_q <= in_pos;
            end else if (zcnt_q != Z_SAT) begin
                zcnt_q <= zcnt_q + 1'b1;
            end
        end
    end

    // Register the decoded bit and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= take;
            out_bit   <= take & head.mark;
            out_err   <= take & head.err;
        end
    end

    // ---------------- assertions ----------------
    a_r9_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> !out_bit);

    a_r8_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

endmodule

// File: rtl/hdb3_codec.sv
// HDB3 codec top: an independent encoder (transmit) and decoder (receive)
// sharing one clock and reset.
// Assumes: both directions run on the same clock.
module hdb3_codec
    import hdb3_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic tx_sym_valid,
    output logic tx_pos,
    output logic tx_neg,
    input  logic rx_valid,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic rx_bit_valid,
    output logic rx_bit,
    output logic rx_code_err
);

    hdb3_enc #(.RUN(RUN)) enc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_bit   (tx_bit),
        .out_valid(tx_sym_valid),
        .out_pos  (tx_pos),
        .out_neg  (tx_neg)
    );

    hdb3_dec #(.RUN(RUN)) dec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_pos   (rx_pos),
        .in_neg   (rx_neg),
        .out_valid(rx_bit_valid),
        .out_bit  (rx_bit),
        .out_err  (rx_code_err)
    );

endmodule

// File: tb/hdb3_codec_tb_top.sv
module hdb3_codec_tb_top;

    localparam int N_ENC = 700;
    localparam int N_DEC = 500;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic rst_n = 1'b0;
    logic tx_valid = 1'b0, tx_bit = 1'b0;
    logic tx_sym_valid, tx_pos, tx_neg;
    logic loop_mode = 1'b1;
    logic drv_valid = 1'b0, drv_pos = 1'b0, drv_neg = 1'b0;
    logic rx_valid, rx_pos, rx_neg;
    logic rx_bit_valid, rx_bit, rx_code_err;

    assign rx_valid = loop_mode ? tx_sym_valid : drv_valid;
    assign rx_pos   = loop_mode ? tx_pos       : drv_pos;
    assign rx_neg   = loop_mode ? tx_neg       : drv_neg;

    hdb3_codec dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_bit(tx_bit),
        .tx_sym_valid(tx_sym_valid), .tx_pos(tx_pos), .tx_neg(tx_neg),
        .rx_valid(rx_valid), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit), .rx_code_err(rx_code_err)
    );

    int vectors = 0, miscompares = 0;
    bit done = 0;
    int in_bits [N_ENC];
    int exp_sym [N_ENC];
    int exp_kind[N_ENC];   // 0 empty, 1 mark, 2 balancing, 3 violation
    int dsym    [N_DEC];   // 1 positive, -1 negative, 0 empty, 2 both rails
    int dexp_bit[N_DEC];
    int dexp_err[N_DEC];
    int enc_seen, dec_seen, acc, prev_acc, last_v_pol;
    bit prev_v, have_v;

    task automatic report(bit ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rail_val(logic p, logic n);
        if (p && n) return 2;
        if (p) return 1;
        if (n) return -1;
        return 0;
    endfunction

    // Expected encoder symbols from the substitution rules.
    function automatic void enc_model();
        int last = -1, par = 0, zr = 0;
        for (int i = 0; i < N_ENC; i++) begin
            if (in_bits[i] != 0) begin
                last = -last; exp_sym[i] = last; exp_kind[i] = 1; par ^= 1; zr = 0;
            end else begin
                zr++; exp_sym[i] = 0; exp_kind[i] = 0;
                if (zr == 4) begin
                    if (par == 0) begin
                        last = -last; exp_sym[i-3] = last; exp_kind[i-3] = 2;
                    end
                    exp_sym[i] = last; exp_kind[i] = 3; par = 0; zr = 0;
                end
            end
        end
    endfunction

    // Expected decoder bits and errors from the receive rules.
    function automatic void dec_model();
        int last = -1, z = 0;
        for (int i = 0; i < N_DEC; i++) begin
            dexp_bit[i] = 0; dexp_err[i] = 0;
            if (dsym[i] == 1 || dsym[i] == -1) begin
                if (dsym[i] == last) begin
                    if (z == 2) begin
                        if (i >= 3) dexp_bit[i-3] = 0;
                    end else if (z != 3) begin
                        dexp_err[i] = 1;
                    end
                end else begin
                    dexp_bit[i] = 1;
                end
                last = dsym[i]; z = 0;
            end else begin
                if (dsym[i] == 2) dexp_err[i] = 1;
                z++;
                if (z >= 4) dexp_err[i] = 1;
            end
        end
    endfunction

    task automatic observe_loop();
        int got;
        string tag;
        bit exp_ov;
        exp_ov = prev_v && (prev_acc >= 4);
        report(tx_sym_valid == exp_ov, "R7", "tx_sym_valid", tx_sym_valid, exp_ov);
        if (tx_sym_valid && enc_seen < N_ENC) begin
            got = rail_val(tx_pos, tx_neg);
            case (exp_kind[enc_seen])
                0:       tag = "R2";
                1:       tag = "R1";
                2:       tag = "R4";
                default: tag = "R3";
            endcase
            report(got == exp_sym[enc_seen], tag, "tx symbol", got, exp_sym[enc_seen]);
            if (enc_seen == 0) report(got == 1, "R6", "first symbol after reset", got, 1);
            if (exp_kind[enc_seen] == 3) begin
                if (have_v) report(got == -last_v_pol, "R5", "violation polarity", got, -last_v_pol);
                last_v_pol = got; have_v = 1;
            end
            enc_seen++;
        end
        if (rx_bit_valid && dec_seen < N_ENC) begin
            report(rx_bit == in_bits[dec_seen][0] && !rx_code_err, "R10", "round trip {err,bit}",
                   {rx_code_err, rx_bit}, in_bits[dec_seen]);
            dec_seen++;
        end
    endtask

    task automatic observe_dec();
        string tag;
        if (rx_bit_valid && dec_seen < N_DEC) begin
            tag = (dexp_err[dec_seen] != 0) ? "R9" : "R8";
            report(rx_bit == dexp_bit[dec_seen][0], tag, "rx_bit", rx_bit, dexp_bit[dec_seen]);
            report(rx_code_err == dexp_err[dec_seen][0], tag, "rx_code_err", rx_code_err, dexp_err[dec_seen]);
            dec_seen++;
        end
    endtask

    task automatic tick_enc(bit v, bit b);
        @(negedge clk);
        observe_loop();
        tx_valid = v; tx_bit = b;
        prev_v = v; prev_acc = acc;
        if (v) acc++;
    endtask

    task automatic tick_dec(bit v, int s);
        @(negedge clk);
        observe_dec();
        drv_valid = v;
        drv_pos = v && (s == 1 || s == 2);
        drv_neg = v && (s == -1 || s == 2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_valid = 0; tx_bit = 0; drv_valid = 0; drv_pos = 0; drv_neg = 0;
        repeat (3) @(negedge clk);
        // R6: all outputs cleared by reset
        report(!tx_sym_valid && !tx_pos && !tx_neg, "R6", "tx outputs in reset",
               {tx_sym_valid, tx_pos, tx_neg}, 0);
        report(!rx_bit_valid && !rx_bit && !rx_code_err, "R6", "rx outputs in reset",
               {rx_bit_valid, rx_bit, rx_code_err}, 0);
        rst_n = 1'b1;
        prev_v = 0; prev_acc = 0; acc = 0; enc_seen = 0; dec_seen = 0; have_v = 0;
    endtask

    // Watchdog: a hang is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R7 watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int pre[23] = '{0,0,0,0, 1,0,0,0,0, 1,1,0,0,0,0, 0,0,0,0,0,0,0,0};
        int dpre[21] = '{1,0,0,1, -1,0,0,0,-1, 1,1, 0,0,0,0,0, 2, -1, 0,1,-1};
        int r;
        void'($urandom(32'd20240611));

        // Phase 1: encoder with loopback into the decoder
        for (int i = 0; i < N_ENC; i++) begin
            if (i < 23) in_bits[i] = pre[i];
            else        in_bits[i] = (($urandom % 100) < 40) ? 1 : 0;
        end
        enc_model();
        loop_mode = 1'b1;
        do_reset();
        for (int i = 0; i < N_ENC; i++) begin
            while (($urandom % 4) == 0) tick_enc(1'b0, 1'b0);
            tick_enc(1'b1, in_bits[i][0]);
        end
        repeat (4) tick_enc(1'b0, 1'b0);
        report(enc_seen == N_ENC - 4, "R7", "symbols emitted", enc_seen, N_ENC - 4);
        report(dec_seen == N_ENC - 8, "R10", "bits recovered", dec_seen, N_ENC - 8);

        // Phase 2: decoder driven directly
        for (int i = 0; i < N_DEC; i++) begin
            if (i < 21) dsym[i] = dpre[i];
            else begin
                r = $urandom % 20;
                if (r < 9)       dsym[i] = 0;
                else if (r < 14) dsym[i] = 1;
                else if (r < 19) dsym[i] = -1;
                else             dsym[i] = 2;
            end
        end
        dec_model();
        loop_mode = 1'b0;
        do_reset();
        for (int i = 0; i < N_DEC; i++) begin
            while (($urandom % 5) == 0) tick_dec(1'b0, 0);
            tick_dec(1'b1, dsym[i]);
        end
        repeat (4) tick_dec(1'b0, 0);
        report(dec_seen == N_DEC - 4, "R8", "decoded count", dec_seen, N_DEC - 4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule